// File: doc/BRIEF.md
# Masked Event Interrupt Controller

This block gathers the status events of an Ethernet controller into one 32-bit event register. It also keeps a 32-bit enable mask and drives thirteen separate interrupt lines, one per implemented event. Hardware blocks report an event with a one-cycle pulse on the matching bit of `hw_evt`. Software acknowledges an event by writing a one to its bit in the event register; bits written as zero are left alone. Each interrupt line is the registered AND of one event bit and the matching mask bit.

The register write port also reaches four more registers: the mask, a control register, a management-frame register and a transmit-control register. Any write to the management-frame register raises the management event. A transmit-control write with its low bit set raises the graceful-stop event. A control write with its low bit set is a soft reset. It clears events, mask and the other registers, drops the enable bit and stops reception. Reception becomes active on an arm pulse, and only while the control enable bit is set.

Top module: `ievt_ctrl`

## Requirements
- R1: After `rst` every output is zero: `irq`, `event_q`, `mask_q`, `mgmt_q`, `txctl_q`, `ctrl_en` and `rx_active`.
- R2: A one on `hw_evt[b]` sets `event_q[b]` on the next clock edge for b in 31..19. Bits 18..0 of `event_q` always read zero.
- R3: A write with `wr_sel`=0 (event register) clears each event bit whose `wr_data` bit is one and leaves the other bits unchanged.
- R4: When a hardware set and a software clear hit the same event bit in one cycle, the bit ends up set.
- R5: Lines 0..12 follow event bits 27, 26, 19, 20, 25, 24, 23, 21, 31, 28, 22, 29, 30 in that order.
- R6: Each `irq` line equals the AND of its event bit and mask bit, registered, so it changes one cycle after the event or mask register changes.
- R7: A write with `wr_sel`=1 loads all 32 bits of `wr_data` into `mask_q`.
- R8: Any write with `wr_sel`=3 loads `mgmt_q` and sets event bit 23 (management).
- R9: A write with `wr_sel`=4 loads `txctl_q`. If `wr_data[0]` is one, it also sets event bit 28 (graceful stop).
- R10: A write with `wr_sel`=2 and `wr_data[0]`=1 clears `event_q`, `mask_q`, `mgmt_q`, `txctl_q`, `ctrl_en` and `rx_active`, even if a hardware event arrives in the same cycle.
- R11: A write with `wr_sel`=2 and `wr_data[0]`=0 loads `ctrl_en` from `wr_data[1]`. A pulse on `rx_arm` sets `rx_active` only while `ctrl_en` is one. A control write with `wr_data[1]`=0 clears `rx_active`.
- R12: Writes with `wr_sel` of 5, 6 or 7 change no register and raise no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select: 0 event, 1 mask, 2 control, 3 management frame, 4 transmit control |
| wr_data | input | 32 | Write data |
| hw_evt | input | 32 | Hardware event set pulses, one per event bit |
| rx_arm | input | 1 | Request to start reception |
| irq | output | 13 | Interrupt lines |
| event_q | output | 32 | Event register |
| mask_q | output | 32 | Mask register |
| mgmt_q | output | 32 | Management-frame register |
| txctl_q | output | 32 | Transmit-control register |
| ctrl_en | output | 1 | Control enable bit |
| rx_active | output | 1 | Reception active |

## Verification
The bench walks each of the thirteen events, one at a time, with a full mask. A single-hot pulse that lands on the wrong line or the wrong event bit shows up as a mapping fault. It repeats each event with only its own mask bit cleared, which separates masking faults from mapping faults. It then acknowledges the event, which shows whether write-one-to-clear touches only the written bits. Multi-bit patterns test the remaining rules:
- pulses on the unimplemented low bits;
- partial clears;
- a set and a clear of the same bit in one cycle;
- a soft reset coinciding with a pulse;
- writes to the unused select codes.

// File: rtl/ievt_pkg.sv
package ievt_pkg;

    localparam int EVT_W   = 32;
    localparam int N_LINES = 13;
    localparam int EVT_LO  = EVT_W - N_LINES;
    localparam int SEL_W   = 3;

    // event bit positions (absolute)
    localparam int B_HBEAT   = 31;
    localparam int B_RXBABL  = 30;
    localparam int B_TXBABL  = 29;
    localparam int B_GSTOP   = 28;
    localparam int B_TXFRM   = 27;
    localparam int B_TXBUF   = 26;
    localparam int B_RXFRM   = 25;
    localparam int B_RXBUF   = 24;
    localparam int B_MGMT    = 23;
    localparam int B_BUSERR  = 22;
    localparam int B_LATECOL = 21;
    localparam int B_RETRY   = 20;
    localparam int B_UNDER   = 19;

    localparam logic [EVT_W-1:0] IMPL_MASK = {{N_LINES{1'b1}}, {EVT_LO{1'b0}}};

    typedef enum logic [SEL_W-1:0] {
        SEL_EVT   = 3'd0,
        SEL_MASK  = 3'd1,
        SEL_CTRL  = 3'd2,
        SEL_MGMT  = 3'd3,
        SEL_TXCTL = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic evt_clr;
        logic mask_wr;
        logic ctrl_wr;
        logic mgmt_wr;
        logic txctl_wr;
        logic soft_rst;
        logic set_mgmt;
        logic set_gstop;
    } wr_dec_t;

    // absolute event bit driving interrupt line i
    function automatic int line_src(input int i);
        case (i)
            0:       return B_TXFRM;
            1:       return B_TXBUF;
            2:       return B_UNDER;
            3:       return B_RETRY;
            4:       return B_RXFRM;
            5:       return B_RXBUF;
            6:       return B_MGMT;
            7:       return B_LATECOL;
            8:       return B_HBEAT;
            9:       return B_GSTOP;
            10:      return B_BUSERR;
            11:      return B_TXBABL;
            default: return B_RXBABL;
        endcase
    endfunction

endpackage

// File: rtl/ievt_wr_decode.sv
module ievt_wr_decode
    import ievt_pkg::*;
(
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [1:0]       ctl_bits,
    output wr_dec_t          dec
);
    reg_sel_e sel;

    always_comb begin
        sel = reg_sel_e'(wr_sel);
        dec = '0;
        if (wr_en) begin
            unique case (sel)
                SEL_EVT:   dec.evt_clr  = 1'b1;
                SEL_MASK:  dec.mask_wr  = 1'b1;
                SEL_CTRL: begin
                    dec.ctrl_wr  = 1'b1;
                    dec.soft_rst = ctl_bits[0];
                end
                SEL_MGMT: begin
                    dec.mgmt_wr  = 1'b1;
                    dec.set_mgmt = 1'b1;
                end
                SEL_TXCTL: begin
                    dec.txctl_wr  = 1'b1;
                    dec.set_gstop = ctl_bits[0];
                end
                default: dec = '0;
            endcase
        end
    end

    always_comb begin
        assert_onehot_R12: assert ($onehot0({dec.evt_clr, dec.mask_wr, dec.ctrl_wr,
                                             dec.mgmt_wr, dec.txctl_wr}));
    end
endmodule

// File: rtl/ievt_event_reg.sv
module ievt_event_reg
    import ievt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  wr_dec_t          dec,
    input  logic [EVT_W-1:0] wr_data,
    input  logic [EVT_W-1:0] hw_evt,
    output logic [EVT_W-1:0] event_q
);
    logic [EVT_W-1:0] set_vec;
    logic [EVT_W-1:0] clr_vec;

    always_comb begin
        set_vec = hw_evt & IMPL_MASK;
        set_vec[B_MGMT]  = set_vec[B_MGMT]  | dec.set_mgmt;
        set_vec[B_GSTOP] = set_vec[B_GSTOP] | dec.set_gstop;
        clr_vec = dec.evt_clr ? wr_data : '0;
    end

    always_ff @(posedge clk) begin
        if (rst || dec.soft_rst) begin
            event_q <= '0;
        end else begin
            // set overrides clear so no event is lost
            event_q <= ((event_q & ~clr_vec) | set_vec) & IMPL_MASK;
        end
    end

    assert_lowbits_R2: assert property (@(posedge clk) disable iff (rst)
        event_q[EVT_LO-1:0] == '0);

    assert_set_wins_R4: assert property (@(posedge clk) disable iff (rst)
        (!dec.soft_rst && |(hw_evt & IMPL_MASK))
        |=> ((event_q & $past(hw_evt & IMPL_MASK)) == $past(hw_evt & IMPL_MASK)));

    assert_w1c_R3: assert property (@(posedge clk) disable iff (rst)
        (dec.evt_clr && (hw_evt & IMPL_MASK) == '0)
        |=> ((event_q & $past(wr_data)) == '0));

    assert_soft_rst_R10: assert property (@(posedge clk) disable iff (rst)
        dec.soft_rst |=> event_q == '0);
endmodule

// File: rtl/ievt_cfg_regs.sv
module ievt_cfg_regs
    import ievt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  wr_dec_t          dec,
    input  logic [EVT_W-1:0] wr_data,
    input  logic             rx_arm,
    output logic [EVT_W-1:0] mask_q,
    output logic [EVT_W-1:0] mgmt_q,
    output logic [EVT_W-1:0] txctl_q,
    output logic             ctrl_en,
    output logic             rx_active
);
    always_ff @(posedge clk) begin
        if (rst || dec.soft_rst) begin
            mask_q    <= '0;
            mgmt_q    <= '0;
            txctl_q   <= '0;
            ctrl_en   <= 1'b0;
            rx_active <= 1'b0;
        end else begin
            if (dec.mask_wr)  mask_q  <= wr_data;
            if (dec.mgmt_wr)  mgmt_q  <= wr_data;
            if (dec.txctl_wr) txctl_q <= wr_data;
            if (dec.ctrl_wr)  ctrl_en <= wr_data[1];
            if (dec.ctrl_wr && !wr_data[1]) begin
                rx_active <= 1'b0;
            end else if (rx_arm && ctrl_en) begin
                rx_active <= 1'b1;
            end
        end
    end

    assert_rx_gate_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_active) |-> $past(ctrl_en));

    assert_soft_rst_cfg_R10: assert property (@(posedge clk) disable iff (rst)
        dec.soft_rst |=> (mask_q == '0 && !ctrl_en && !rx_active));

    assert_mask_load_R7: assert property (@(posedge clk) disable iff (rst)
        dec.mask_wr |=> mask_q == $past(wr_data));
endmodule

// File: rtl/ievt_line_map.sv
module ievt_line_map
    import ievt_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [N_LINES-1:0] ev_hi,
    input  logic [N_LINES-1:0] mask_hi,
    output logic [N_LINES-1:0] irq
);
    logic [N_LINES-1:0] active;

    assign active = ev_hi & mask_hi;

    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        localparam int SRC = line_src(i) - EVT_LO;
        always_ff @(posedge clk) begin
            if (rst) irq[i] <= 1'b0;
            else     irq[i] <= active[SRC];
        end
    end

    assert_mgmt_line_R5: assert property (@(posedge clk) disable iff (rst)
        irq[6] |-> $past(ev_hi[B_MGMT - EVT_LO] && mask_hi[B_MGMT - EVT_LO]));

    assert_masked_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        (mask_hi == '0) |=> irq == '0);
endmodule

// File: rtl/ievt_ctrl.sv
module ievt_ctrl
    import ievt_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [2:0]   wr_sel,
    input  logic [31:0]  wr_data,
    input  logic [31:0]  hw_evt,
    input  logic         rx_arm,
    output logic [12:0]  irq,
    output logic [31:0]  event_q,
    output logic [31:0]  mask_q,
    output logic [31:0]  mgmt_q,
    output logic [31:0]  txctl_q,
    output logic         ctrl_en,
    output logic         rx_active
);
    wr_dec_t dec;

    ievt_wr_decode u_dec (
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .ctl_bits (wr_data[1:0]),
        .dec      (dec)
    );

    ievt_event_reg u_evt (
        .clk     (clk),
        .rst     (rst),
        .dec     (dec),
        .wr_data (wr_data),
        .hw_evt  (hw_evt),
        .event_q (event_q)
    );

    ievt_cfg_regs u_cfg (
        .clk       (clk),
        .rst       (rst),
        .dec       (dec),
        .wr_data   (wr_data),
        .rx_arm    (rx_arm),
        .mask_q    (mask_q),
        .mgmt_q    (mgmt_q),
        .txctl_q   (txctl_q),
        .ctrl_en   (ctrl_en),
        .rx_active (rx_active)
    );

    ievt_line_map u_map (
        .clk     (clk),
        .rst     (rst),
        .ev_hi   (event_q[EVT_W-1:EVT_LO]),
        .mask_hi (mask_q[EVT_W-1:EVT_LO]),
        .irq     (irq)
    );

    assert_mgmt_evt_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 3'd3) |=> event_q[B_MGMT]);

    assert_gstop_evt_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 3'd4 && wr_data[0]) |=> event_q[B_GSTOP]);

    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (irq == '0 && event_q == '0 && mask_q == '0 && !rx_active));
endmodule

// File: tb/tb_ievt_ctrl.sv
module tb_ievt_ctrl;
    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [2:0]  wr_sel;
    logic [31:0] wr_data;
    logic [31:0] hw_evt;
    logic        rx_arm;
    logic [12:0] irq;
    logic [31:0] event_q, mask_q, mgmt_q, txctl_q;
    logic        ctrl_en, rx_active;

    int checks = 0;
    int errors = 0;
    int src [13] = '{27, 26, 19, 20, 25, 24, 23, 21, 31, 28, 22, 29, 30};

    always #10 clk = ~clk;

    ievt_ctrl dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .hw_evt(hw_evt), .rx_arm(rx_arm), .irq(irq), .event_q(event_q),
        .mask_q(mask_q), .mgmt_q(mgmt_q), .txctl_q(txctl_q),
        .ctrl_en(ctrl_en), .rx_active(rx_active)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // apply for one clock edge, then return at the next falling edge
    task automatic step(input logic we, input logic [2:0] sel, input logic [31:0] d,
                        input logic [31:0] hw, input logic arm);
        wr_en = we; wr_sel = sel; wr_data = d; hw_evt = hw; rx_arm = arm;
        @(negedge clk);
        wr_en = 1'b0; wr_sel = 3'd0; wr_data = '0; hw_evt = '0; rx_arm = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    function automatic logic [12:0] lines_of(input logic [31:0] ev, input logic [31:0] mk);
        logic [12:0] r;
        for (int k = 0; k < 13; k++) r[k] = ev[src[k]] & mk[src[k]];
        return r;
    endfunction

    initial begin
        int cycles = 0;
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                checks++; errors++;
                $display("FAIL watchdog: actual %0d expected <20000", cycles);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        logic [31:0] one;
        rst = 1'b1; wr_en = 0; wr_sel = 0; wr_data = 0; hw_evt = 0; rx_arm = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 irq", {19'd0, irq}, 32'd0);
        chk("R1 event", event_q, 32'd0);
        chk("R1 mask", mask_q, 32'd0);
        chk("R1 mgmt", mgmt_q, 32'd0);
        chk("R1 txctl", txctl_q, 32'd0);
        chk("R1 en/rx", {30'd0, ctrl_en, rx_active}, 32'd0);

        // sweep every line with full mask, then masked-out, then acknowledge
        step(1, 3'd1, 32'hFFFF_FFFF, 0, 0);
        chk("R7 mask load", mask_q, 32'hFFFF_FFFF);
        for (int i = 0; i < 13; i++) begin
            one = 32'd1 << src[i];
            step(0, 0, 0, one, 0);
            chk("R2 single set", event_q, one);
            idle();
            chk("R5 line map", {19'd0, irq}, {19'd0, 13'd1 << i});
            step(1, 3'd1, ~one, 0, 0);
            idle();
            chk("R6 masked line", {19'd0, irq}, 32'd0);
            step(1, 3'd0, one, 0, 0);
            chk("R3 ack", event_q, 32'd0);
            step(1, 3'd1, 32'hFFFF_FFFF, 0, 0);
        end

        // low bits are not implemented
        step(0, 0, 0, 32'h0007_FFFF, 0);
        chk("R2 low bits", event_q, 32'd0);

        // partial clear
        step(0, 0, 0, 32'hFFFF_FFFF, 0);
        chk("R2 all set", event_q, 32'hFFF8_0000);
        idle();
        chk("R6 all lines", {19'd0, irq}, 32'h0000_1FFF);
        step(1, 3'd0, 32'hA005_0000, 0, 0);
        chk("R3 partial", event_q, 32'h5FF8_0000 & ~32'h0005_0000);
        step(1, 3'd1, 32'h0F0F_0000, 0, 0);
        idle();
        chk("R6 pattern", {19'd0, irq}, {19'd0, lines_of(event_q, 32'h0F0F_0000)});

        // set wins over same-cycle clear
        step(1, 3'd0, 32'hFFFF_FFFF, 32'h0100_0000, 0);
        chk("R4 set wins", event_q, 32'h0100_0000);

        // management and transmit-control writes
        step(1, 3'd3, 32'h1234_5678, 0, 0);
        chk("R8 mgmt value", mgmt_q, 32'h1234_5678);
        chk("R8 mgmt event", event_q, 32'h0180_0000);
        step(1, 3'd4, 32'h0000_0002, 0, 0);
        chk("R9 txctl no gstop", event_q, 32'h0180_0000);
        step(1, 3'd4, 32'h0000_0003, 0, 0);
        chk("R9 txctl value", txctl_q, 32'h0000_0003);
        chk("R9 gstop", event_q, 32'h1180_0000);

        // unused selects
        for (int s = 5; s < 8; s++) begin
            step(1, 3'(s), 32'hFFFF_FFFF, 0, 0);
            chk("R12 unused event", event_q, 32'h1180_0000);
            chk("R12 unused mask", mask_q, 32'h0F0F_0000);
            chk("R12 unused regs", mgmt_q ^ txctl_q, 32'h1234_567B);
        end

        // receive gating
        step(0, 0, 0, 0, 1);
        chk("R11 arm disabled", {31'd0, rx_active}, 32'd0);
        step(1, 3'd2, 32'h0000_0002, 0, 0);
        chk("R11 enable", {31'd0, ctrl_en}, 32'd1);
        step(0, 0, 0, 0, 1);
        chk("R11 arm enabled", {31'd0, rx_active}, 32'd1);
        step(1, 3'd2, 32'h0000_0000, 0, 0);
        chk("R11 disable", {30'd0, ctrl_en, rx_active}, 32'd0);
        step(1, 3'd2, 32'h0000_0002, 0, 0);
        step(0, 0, 0, 0, 1);

        // soft reset with coincident hardware event
        step(1, 3'd2, 32'h0000_0003, 32'hFFFF_FFFF, 0);
        chk("R10 event", event_q, 32'd0);
        chk("R10 mask", mask_q, 32'd0);
        chk("R10 regs", mgmt_q | txctl_q, 32'd0);
        chk("R10 en/rx", {30'd0, ctrl_en, rx_active}, 32'd0);
        idle();
        chk("R10 lines", {19'd0, irq}, 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule